// File: doc/BRIEF.md
# Stuck Bus Detector and Recovery Sequencer

This block watches the board-side clock and data lines of a two-wire bus. It declares a fault when either line has been held low for too long. The time limit restarts only when both lines are seen high together. Once a fault is declared, two strap inputs select what happens next. With no strap set, the block only raises a fault flag and the connection stays up. With the disconnect strap, it asks for the board side to be isolated and precharged until the lines come free. With the clock-recovery strap, it first releases every line for a settle interval. It then drives a fixed train of open-drain low pulses onto board SCL to walk a hung slave out of its transfer.

Whenever recovery ends, the block sends a one-cycle return-to-wait pulse to the separate connect controller and restarts its stuck timer. Recovery ends when the bus frees, when the governing strap is withdrawn, or after a parked wait. All timing is counted in clock cycles. At a 10 MHz clock the defaults give a 30 ms stuck limit, a 50 µs release interval and 8 kHz pulses. All ports are plain control and status levels; there is no data stream and so no handshake.

Top module: `i2c_stuck_recovery`

## Requirements
- R1: A fault is declared after STUCK_CYC consecutive sampled cycles in which board SCL or board SDA is low. Any sampled cycle with both lines high clears the count to zero.
- R2: The fault output rises in the cycle the limit is reached. It stays high, in every state, until a cycle in which both board lines are sampled high. It drops right after that cycle.
- R3: With neither strap set, a stuck bus raises only the fault flag. The disconnect, precharge and SCL pull outputs stay low.
- R4: With the clock-recovery strap set, the cycle after the fault rises starts a release phase. In that phase disconnect and precharge are high and the SCL pull is low, for GAP_CYC cycles.
- R5: After the release phase, the SCL pull output goes high for HALF_CYC cycles and low for HALF_CYC cycles, NUM_PULSES times. It is never high while disconnect is low.
- R6: If both board lines are sampled high during the release phase or the pulse train, disconnect and precharge drop on the next edge. On that same edge, to_wait_o is high for exactly one cycle.
- R7: If the bus is still stuck after the last pulse, disconnect and precharge stay high with no further pulses. When both lines are sampled high, the block returns to wait and pulses to_wait_o.
- R8: With only the disconnect strap set, a stuck bus drives disconnect and precharge high without any SCL pulses. This holds until both lines are sampled high, and then to_wait_o pulses.
- R9: Dropping the clock-recovery strap during release or pulsing returns the block to wait on the next edge, with a to_wait_o pulse. Dropping the disconnect strap while disconnected does the same.
- R10: Every return to wait restarts the stuck count from zero. After that edge, recovery can start again only once the lines have been low for STUCK_CYC further cycles.
- R11: With both straps set, the block behaves exactly as with clock recovery alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brd_scl_i | input | 1 | Sampled level of board-side SCL |
| brd_sda_i | input | 1 | Sampled level of board-side SDA |
| strap_clk_rec_i | input | 1 | Strap: force clock pulses on a stuck bus |
| strap_disc_i | input | 1 | Strap: disconnect on a stuck bus |
| fault_o | output | 1 | Stuck-bus fault flag, active high |
| disconnect_o | output | 1 | Request to isolate board side from backplane |
| precharge_o | output | 1 | Request to precharge all bus lines |
| scl_pull_o | output | 1 | Open-drain pull-down enable for board SCL |
| to_wait_o | output | 1 | One-cycle return-to-wait pulse to the connect controller |

## Verification
The bench builds the block with STUCK_CYC of 20, GAP_CYC of 5, HALF_CYC of 3 and the default sixteen pulses. With these values a full detect, release, pulse-train and park sequence fits in about 130 cycles, so every exit path can be reached in a short run. These include freeing during release, freeing mid-train, the parked wait, both strap withdrawals and the restarted count after an abort. The pulse count stays at its real value of sixteen, so the train's length and count are checked as built. The small release and half-period values still leave several cycles in each phase, so off-by-one errors at phase edges show up.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // Recovery sequencer states
  typedef enum logic [2:0] {
    ST_WATCH   = 3'd0,  // connected, stuck timer running
    ST_RELEASE = 3'd1,  // all lines released before clocking
    ST_CLOCK   = 3'd2,  // forced SCL pulse train
    ST_PARK    = 3'd3,  // train done, bus still stuck
    ST_HOLD    = 3'd4   // disconnect-only recovery
  } rec_state_t;

endpackage

// File: rtl/sbr_stuck_timer.sv
module sbr_stuck_timer #(
  parameter int STUCK_CYC = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,        // count only while watching
  input  logic both_high,  // board SCL and SDA both high
  output logic stuck,
  output logic fault
);

  localparam int CW = $clog2(STUCK_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STUCK_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fault_q, fault_d;

  always_comb begin
    if (!arm || both_high)  cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_comb begin
    if (both_high)           fault_d = 1'b0;
    else if (cnt_d == LIMIT) fault_d = 1'b1;
    else                     fault_d = fault_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign stuck = (cnt_q == LIMIT);
  assign fault = fault_q;

  AST_FAULT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    both_high |=> !fault); // R2
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    both_high |=> !stuck); // R1
  AST_STUCK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    stuck |-> fault || $past(both_high)); // R2

endmodule

// File: rtl/sbr_pulse_gen.sv
module sbr_pulse_gen #(
  parameter int HALF_CYC   = 625,
  parameter int NUM_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pull,
  output logic last
);

  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int PW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
  localparam logic [HW-1:0] PH_LAST  = HW'(HALF_CYC - 1);
  localparam logic [PW-1:0] IDX_LAST = PW'(NUM_PULSES - 1);

  logic [HW-1:0] ph_q;
  logic          hi_q;   // 0: low half, 1: released half
  logic [PW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ph_q  <= '0;
      hi_q  <= 1'b0;
      idx_q <= '0;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
      hi_q <= ~hi_q;
      if (hi_q) idx_q <= idx_q + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign pull = run && !hi_q;
  assign last = run && hi_q && (ph_q == PH_LAST) && (idx_q == IDX_LAST);

  generate
    if (HALF_CYC > 1) begin : g_half_chk
      AST_PULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $rose(pull)) |=> (pull || !run)); // R5
    end
  endgenerate

endmodule

// File: rtl/sbr_recovery_fsm.sv
module sbr_recovery_fsm
  import sbr_pkg::*;
#(
  parameter int GAP_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stuck,
  input  logic       both_high,
  input  logic       clk_en,
  input  logic       disc_en,
  input  logic       pulse_last,
  output rec_state_t state,
  output logic       to_wait
);

  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  rec_state_t    st_q, st_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          tw_q, tw_d;
  logic          leave_clk;

  always_comb begin
    st_d      = st_q;
    gap_d     = gap_q;
    tw_d      = 1'b0;
    leave_clk = both_high || !clk_en;
    unique case (st_q)
      ST_WATCH: begin
        gap_d = '0;
        if (stuck && !both_high) begin
          if (clk_en)       st_d = ST_RELEASE;  // clock recovery wins
          else if (disc_en) st_d = ST_HOLD;
        end
      end
      ST_RELEASE: begin
        if (leave_clk) begin
          st_d = ST_WATCH;
          tw_d = 1'b1;
        end else if (gap_q == GAP_LAST) begin
          st_d  = ST_CLOCK;
          gap_d = '0;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      ST_CLOCK: begin
        if (leave_clk) begin
          st_d = ST_WATCH;
          tw_d = 1'b1;
        end else if (pulse_last) begin
          st_d = ST_PARK;
        end
      end
      ST_PARK: begin
        if (both_high) begin
          st_d = ST_WATCH;
          tw_d = 1'b1;
        end
      end
      ST_HOLD: begin
        if (both_high || !disc_en) begin
          st_d = ST_WATCH;
          tw_d = 1'b1;
        end
      end
      default: st_d = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_WATCH;
      gap_q <= '0;
      tw_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      gap_q <= gap_d;
      tw_q  <= tw_d;
    end
  end

  assign state   = st_q;
  assign to_wait = tw_q;

  AST_CLK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RELEASE || st_q == ST_CLOCK) && !clk_en) |=> (st_q == ST_WATCH && to_wait)); // R9
  AST_DISC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !disc_en) |=> (st_q == ST_WATCH && to_wait)); // R9
  AST_NO_STRAP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WATCH && !clk_en && !disc_en) |=> st_q == ST_WATCH); // R3
  AST_CLK_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WATCH && stuck && !both_high && clk_en) |=> st_q == ST_RELEASE); // R11
  AST_WAIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    to_wait |=> !to_wait); // R6
  AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARK && !both_high) |=> st_q == ST_PARK); // R7

endmodule

// File: rtl/i2c_stuck_recovery.sv
module i2c_stuck_recovery
  import sbr_pkg::*;
#(
  parameter int STUCK_CYC  = 300000,
  parameter int GAP_CYC    = 500,
  parameter int HALF_CYC   = 625,
  parameter int NUM_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brd_scl_i,
  input  logic brd_sda_i,
  input  logic strap_clk_rec_i,
  input  logic strap_disc_i,
  output logic fault_o,
  output logic disconnect_o,
  output logic precharge_o,
  output logic scl_pull_o,
  output logic to_wait_o
);

  logic       both_high;
  logic       stuck;
  logic       pulse_last;
  logic       pulse_pull;
  rec_state_t state;

  assign both_high = brd_scl_i && brd_sda_i;

  sbr_stuck_timer #(.STUCK_CYC(STUCK_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (state == ST_WATCH),
    .both_high (both_high),
    .stuck     (stuck),
    .fault     (fault_o)
  );

  sbr_recovery_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stuck      (stuck),
    .both_high  (both_high),
    .clk_en     (strap_clk_rec_i),
    .disc_en    (strap_disc_i),
    .pulse_last (pulse_last),
    .state      (state),
    .to_wait    (to_wait_o)
  );

  sbr_pulse_gen #(.HALF_CYC(HALF_CYC), .NUM_PULSES(NUM_PULSES)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_CLOCK),
    .pull  (pulse_pull),
    .last  (pulse_last)
  );

  assign disconnect_o = (state != ST_WATCH);
  assign precharge_o  = (state != ST_WATCH);
  assign scl_pull_o   = pulse_pull;

  AST_PULL_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_o |-> disconnect_o); // R5
  AST_WAIT_RECONNECTS: assert property (@(posedge clk) disable iff (!rst_n)
    to_wait_o |-> !disconnect_o && !precharge_o); // R6

endmodule

// File: tb/sim_i2c_stuck_recovery.sv
module sim_i2c_stuck_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int S = 20, G = 5, H = 3, N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, ce = 1'b0, de = 1'b0;
  logic fault, disc, pre, pull, tw;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stuck_recovery #(.STUCK_CYC(S), .GAP_CYC(G), .HALF_CYC(H), .NUM_PULSES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .brd_scl_i(scl), .brd_sda_i(sda),
    .strap_clk_rec_i(ce), .strap_disc_i(de),
    .fault_o(fault), .disconnect_o(disc), .precharge_o(pre),
    .scl_pull_o(pull), .to_wait_o(tw));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference model: 0 watch, 1 release, 2 clock, 3 park, 4 hold
  int m_cnt, m_flt, m_st, m_t, m_ph, m_hi, m_idx, m_tw;
  int old_st, old_cnt;
  bit bh, back;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_flt = 0; m_st = 0; m_t = 0; m_ph = 0; m_hi = 0; m_idx = 0; m_tw = 0;
    end else begin
      bh = scl && sda; old_st = m_st; old_cnt = m_cnt; back = 0; m_tw = 0;
      case (old_st)
        0: if (old_cnt == S && !bh) begin
             if (ce) begin m_st = 1; m_t = 0; end
             else if (de) m_st = 4;
           end
        1: if (bh || !ce) back = 1;
           else if (m_t == G-1) begin m_st = 2; m_ph = 0; m_hi = 0; m_idx = 0; end
           else m_t++;
        2: if (bh || !ce) back = 1;
           else if (m_hi == 1 && m_ph == H-1 && m_idx == N-1) m_st = 3;
           else if (m_ph == H-1) begin
             m_ph = 0;
             if (m_hi == 1) begin m_hi = 0; m_idx++; end else m_hi = 1;
           end else m_ph++;
        3: if (bh) back = 1;
        4: if (bh || !de) back = 1;
        default: ;
      endcase
      if (back) begin m_st = 0; m_tw = 1; end
      m_cnt = (old_st != 0 || bh) ? 0 : ((old_cnt < S) ? old_cnt + 1 : S);
      m_flt = bh ? 0 : ((m_cnt == S) ? 1 : m_flt);
    end
    #1;
    if (rst_n && !done) begin
      chk("R1 fault_o", int'(fault), m_flt);
      chk("R4 disconnect_o", int'(disc), (m_st != 0) ? 1 : 0);
      chk("R8 precharge_o", int'(pre), (m_st != 0) ? 1 : 0);
      chk("R5 scl_pull_o", int'(pull), (m_st == 2 && m_hi == 0) ? 1 : 0);
      chk("R6 to_wait_o", int'(tw), m_tw);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    scl = 1; sda = 1; ce = 0; de = 0;
    cyc(4);
  endtask

  initial begin
    int n, rises, lows;
    bit prev;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // reset state
    chk("R2 reset fault", fault, 0);
    chk("R4 reset disconnect", disc, 0);
    chk("R5 reset pull", pull, 0);
    chk("R6 reset to_wait", tw, 0);

    // R1: glitches shorter than the limit never fault, count restarts
    sda = 0; cyc(S-1); sda = 1; cyc(1);
    scl = 0; cyc(S-1);
    chk("R1 restart no fault", fault, 0);
    idle();

    // R3: no straps, fault only
    sda = 0; n = 0;
    repeat (S + 20) begin cyc(1); if (disc || pull || pre) n++; end
    chk("R3 fault only", fault, 1);
    chk("R3 no recovery action", n, 0);
    sda = 1; cyc(1);
    chk("R2 fault clears", fault, 0);
    idle();

    // R1 R4 R5 R7: full clock recovery, bus stays stuck
    scl = 0; ce = 1;
    cyc(S-1);
    chk("R1 fault before limit", fault, 0);
    cyc(1);
    chk("R1 fault at limit", fault, 1);
    chk("R4 not yet disconnected", disc, 0);
    cyc(1);
    chk("R4 disconnect", disc, 1);
    chk("R4 precharge", pre, 1);
    chk("R4 released", pull, 0);
    n = 0;
    while (!pull && n < 50) begin n++; cyc(1); end
    chk("R4 release length", n, G);
    rises = 0; lows = 0; prev = 0;
    repeat (2*N*H + 5) begin
      if (pull) lows++;
      if (pull && !prev) rises++;
      prev = pull;
      cyc(1);
    end
    chk("R5 pulse count", rises, N);
    chk("R5 low cycles", lows, N*H);
    chk("R7 parked disconnect", disc, 1);
    cyc(10);
    chk("R7 still parked", disc, 1);
    chk("R7 no pulses", pull, 0);
    scl = 1; cyc(1);
    chk("R7 return disconnect", disc, 0);
    chk("R7 to_wait", tw, 1);
    chk("R2 fault cleared", fault, 0);
    cyc(1);
    chk("R6 to_wait one cycle", tw, 0);
    idle();

    // R6: bus frees mid-train
    sda = 0; ce = 1;
    cyc(S + 1 + G + 4);
    chk("R6 in train", disc, 1);
    sda = 1; cyc(1);
    chk("R6 reconnect", disc, 0);
    chk("R6 to_wait", tw, 1);
    idle();

    // R6: bus frees during release
    sda = 0; ce = 1;
    cyc(S + 3);
    sda = 1; cyc(1);
    chk("R6 free in release", tw, 1);
    idle();

    // R8: disconnect only
    scl = 0; de = 1;
    cyc(S + 1);
    chk("R8 disconnect", disc, 1);
    n = 0;
    repeat (40) begin cyc(1); if (pull) n++; end
    chk("R8 no pulses", n, 0);
    chk("R8 precharge", pre, 1);
    scl = 1; cyc(1);
    chk("R8 to_wait", tw, 1);
    idle();

    // R9: disconnect strap withdrawn
    scl = 0; de = 1;
    cyc(S + 3);
    de = 0; cyc(1);
    chk("R9 disc abort", disc, 0);
    chk("R9 disc abort to_wait", tw, 1);
    chk("R2 fault held", fault, 1);
    idle();

    // R9 R10: clock strap withdrawn, then restored while still stuck
    sda = 0; ce = 1;
    cyc(S + 1 + G + 4);
    ce = 0; cyc(1);
    chk("R9 clk abort", disc, 0);
    chk("R9 clk abort to_wait", tw, 1);
    chk("R2 fault kept", fault, 1);
    ce = 1;
    cyc(S);
    chk("R10 timer restarted", disc, 0);
    cyc(1);
    chk("R10 re-detect", disc, 1);
    idle();

    // R11: both straps means clock recovery
    scl = 0; ce = 1; de = 1;
    cyc(S + 1 + G);
    chk("R11 pulses with both straps", pull, 1);
    idle();

    finish_run();
  end
endmodule